// File: doc/BRIEF.md
# Circular-Buffer FIR Stream Filter

This block is a streaming finite impulse response filter. Samples arrive on a stream slave port and are written into a sample memory organised as a ring: a write pointer advances by one entry for every accepted sample and wraps from the last entry back to the first. For each accepted sample the block computes one output, y[n] = sum over k from 0 to T-1 of h[k]·x[n-k], by walking a coefficient index forward from zero while a read index walks the ring backward from the newest sample. One multiplier and one adder do all the work, with the product and the accumulation in separate pipeline stages, so an output costs T issue cycles plus two pipeline cycles.

The finished result is captured in an output latch and offered on a stream master port; it stays there, unchanged, until the downstream side takes it. Only one sample is in flight at a time, and no new sample is taken while a result is still waiting, so a slow consumer throttles the producer. Coefficients are loaded through a simple write port, the tap count and the frame length come from configuration inputs, and the last output of each frame is marked.

Top module: `fir_stream_top`

## Requirements
- R1: In the cycle after reset is released, s_tready is 1, m_tvalid is 0 and m_tlast is 0.
- R2: Each output equals the sum over k = 0..T-1 of coef[k]·x[n-k], where coef[k] is the value last written with coef_idx = k, x[n] is the sample just accepted and samples that would precede the first sample after reset count as zero.
- R3: Products and sums are 32-bit two's complement and wrap modulo 2^32 without saturation.
- R4: m_tvalid first reads 1 after the (T+2)th rising edge following the edge that accepts a sample.
- R5: Once a sample is accepted, s_tready stays 0 until the resulting output has been handed off; it never stays 1 on the edge after an acceptance.
- R6: While m_tvalid is 1 and m_tready is 0, m_tvalid stays 1 and m_tdata and m_tlast do not change.
- R7: The sample memory is a ring of DEPTH entries: after more than DEPTH samples, an output with T = DEPTH uses exactly the DEPTH newest samples.
- R8: The tap count T is cfg_taps captured at acceptance, with 0 treated as 1 and values above DEPTH treated as DEPTH.
- R9: m_tlast is 1 on the output produced by every cfg_len-th accepted sample after reset (sample indices cfg_len-1, 2·cfg_len-1, ...) and 0 on the others; m_tlast is never 1 while m_tvalid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cfg_taps | input | AW+1 | Requested tap count |
| cfg_len | input | LEN_W | Samples per frame, used for m_tlast |
| coef_we | input | 1 | Coefficient write strobe |
| coef_idx | input | AW | Coefficient index written |
| coef_data | input | DATA_W | Coefficient value written |
| s_tvalid | input | 1 | Input sample valid |
| s_tready | output | 1 | Block can accept a sample |
| s_tdata | input | DATA_W | Input sample, signed |
| m_tvalid | output | 1 | Output result valid |
| m_tready | input | 1 | Downstream accepts the result |
| m_tdata | output | DATA_W | Filtered result, signed |
| m_tlast | output | 1 | Marks the last result of a frame |

## Verification
The bench goes after the start of the history, where missing older samples must read as zero; a design that reads uninitialised ring entries returns garbage for the first T-1 outputs. It runs more samples than the ring holds with the full tap count, which a read pointer that fails to wrap backward would answer with stale or misordered samples. It holds the consumer off for many cycles to catch a latch that lets the result drift or a ready that lets a second sample in, and it drives tap counts of zero and above DEPTH, where a missing clamp gives a zero result or an overrun walk with the wrong latency. Large operands check that the arithmetic wraps instead of saturating, and a short frame length checks that the frame marker lands on every cfg_len-th output.

// File: rtl/fir_stream_pkg.sv
package fir_stream_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_WAIT = 2'd2
  } ctl_state_t;

endpackage

// File: rtl/fir_sample_ring.sv
module fir_sample_ring #(
  parameter int DATA_W = 32,
  parameter int AW     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [AW-1:0]     tap_k,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;

  logic [DATA_W-1:0] ring_mem [DEPTH];
  logic [AW-1:0]     wr_ptr;
  logic [AW-1:0]     newest;
  logic [AW-1:0]     rd_addr;

  // backward walk from the newest entry, wrapping modulo DEPTH
  assign rd_addr = newest - tap_k;

  always_ff @(posedge clk) begin
    if (wr_en) ring_mem[wr_ptr] <= wr_data;
    rd_data <= ring_mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      newest <= '0;
    end else if (wr_en) begin
      newest <= wr_ptr;
      wr_ptr <= wr_ptr + 1'b1;
    end
  end

endmodule

// File: rtl/fir_coef_bank.sv
module fir_coef_bank #(
  parameter int DATA_W = 32,
  parameter int AW     = 4
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [AW-1:0]     rd_idx,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;

  logic [DATA_W-1:0] coef_mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) coef_mem[wr_idx] <= wr_data;
    rd_data <= coef_mem[rd_idx];
  end

endmodule

// File: rtl/fir_mac_pipe.sv
module fir_mac_pipe #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              iss_v,
  input  logic              iss_use,
  input  logic              iss_last,
  input  logic [DATA_W-1:0] x_rd,
  input  logic [DATA_W-1:0] h_rd,
  output logic              fin,
  output logic [DATA_W-1:0] sum
);
  logic              v1, use1, last1;
  logic              v2, last2;
  logic [DATA_W-1:0] op_x, op_h;
  logic [DATA_W-1:0] prod_q;
  logic [DATA_W-1:0] acc_q;

  // operands held at zero unless a live, in-history tap is in stage 1
  assign op_x = (v1 && use1) ? x_rd : '0;
  assign op_h = (v1 && use1) ? h_rd : '0;

  assign fin = v2 && last2;
  assign sum = acc_q + prod_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      v1     <= 1'b0;
      use1   <= 1'b0;
      last1  <= 1'b0;
      v2     <= 1'b0;
      last2  <= 1'b0;
      prod_q <= '0;
      acc_q  <= '0;
    end else begin
      v1     <= iss_v;
      use1   <= iss_use;
      last1  <= iss_v && iss_last;
      v2     <= v1;
      last2  <= v1 && last1;
      prod_q <= DATA_W'(op_x * op_h);
      if (clear)   acc_q <= '0;
      else if (v2) acc_q <= sum;
    end
  end

endmodule

// File: rtl/fir_stream_top.sv
module fir_stream_top
  import fir_stream_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AW     = 4,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW:0]       cfg_taps,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic              coef_we,
  input  logic [AW-1:0]     coef_idx,
  input  logic [DATA_W-1:0] coef_data,
  input  logic              s_tvalid,
  output logic              s_tready,
  input  logic [DATA_W-1:0] s_tdata,
  output logic              m_tvalid,
  input  logic              m_tready,
  output logic [DATA_W-1:0] m_tdata,
  output logic              m_tlast
);
  localparam int DEPTH = 1 << AW;
  localparam logic [AW:0] DEPTH_C = (AW+1)'(DEPTH);

  ctl_state_t        state;
  logic [AW-1:0]     tap_k;
  logic [AW:0]       taps_q;
  logic [AW:0]       taps_eff;
  logic [AW:0]       n_seen;
  logic [LEN_W-1:0]  frame_cnt;
  logic              cur_last;
  logic              accept;
  logic              iss_v, iss_use, iss_last;
  logic [DATA_W-1:0] x_rd, h_rd;
  logic              fin;
  logic [DATA_W-1:0] sum;
  logic              out_v, out_l;
  logic [DATA_W-1:0] out_d;
  logic              frame_end;

  always_comb begin
    if (cfg_taps == '0)          taps_eff = (AW+1)'(1);
    else if (cfg_taps > DEPTH_C) taps_eff = DEPTH_C;
    else                         taps_eff = cfg_taps;
  end

  assign s_tready  = (state == ST_IDLE) && !out_v;
  assign accept    = s_tvalid && s_tready;
  assign iss_v     = (state == ST_RUN);
  assign iss_use   = ({1'b0, tap_k} < n_seen);
  assign iss_last  = ({1'b0, tap_k} == taps_q - 1'b1);
  assign frame_end = (frame_cnt == cfg_len - 1'b1);

  fir_sample_ring #(.DATA_W(DATA_W), .AW(AW)) ring_i (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (accept),
    .wr_data (s_tdata),
    .tap_k   (tap_k),
    .rd_data (x_rd)
  );

  fir_coef_bank #(.DATA_W(DATA_W), .AW(AW)) coef_i (
    .clk     (clk),
    .wr_en   (coef_we),
    .wr_idx  (coef_idx),
    .wr_data (coef_data),
    .rd_idx  (tap_k),
    .rd_data (h_rd)
  );

  fir_mac_pipe #(.DATA_W(DATA_W)) mac_i (
    .clk      (clk),
    .rst      (rst),
    .clear    (accept),
    .iss_v    (iss_v),
    .iss_use  (iss_use),
    .iss_last (iss_last),
    .x_rd     (x_rd),
    .h_rd     (h_rd),
    .fin      (fin),
    .sum      (sum)
  );

  // control sequence: idle -> issue T taps -> wait for pipeline drain
  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      tap_k  <= '0;
      taps_q <= (AW+1)'(1);
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          state  <= ST_RUN;
          tap_k  <= '0;
          taps_q <= taps_eff;
        end
        ST_RUN: begin
          tap_k <= tap_k + 1'b1;
          if (iss_last) state <= ST_WAIT;
        end
        ST_WAIT: if (fin) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // history depth and frame position
  always_ff @(posedge clk) begin
    if (rst) begin
      n_seen    <= '0;
      frame_cnt <= '0;
      cur_last  <= 1'b0;
    end else if (accept) begin
      if (n_seen != DEPTH_C) n_seen <= n_seen + 1'b1;
      cur_last  <= frame_end;
      frame_cnt <= frame_end ? '0 : frame_cnt + 1'b1;
    end
  end

  // output latch
  always_ff @(posedge clk) begin
    if (rst) begin
      out_v <= 1'b0;
      out_l <= 1'b0;
      out_d <= '0;
    end else if (fin) begin
      out_v <= 1'b1;
      out_l <= cur_last;
      out_d <= sum;
    end else if (out_v && m_tready) begin
      out_v <= 1'b0;
      out_l <= 1'b0;
    end
  end

  assign m_tvalid = out_v;
  assign m_tdata  = out_d;
  assign m_tlast  = out_l;

endmodule

// File: rtl/fir_stream_chk.sv
module fir_stream_chk #(
  parameter int DATA_W = 32,
  parameter int AW     = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [AW:0]       cfg_taps,
  input logic              s_tvalid,
  input logic              s_tready,
  input logic              m_tvalid,
  input logic              m_tready,
  input logic [DATA_W-1:0] m_tdata,
  input logic              m_tlast
);
  localparam int DEPTH = 1 << AW;
  localparam int CW    = AW + 3;

  logic [CW-1:0] since_acc;
  logic [CW-1:0] want_lat;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_acc <= '0;
      want_lat  <= CW'(3);
    end else if (s_tvalid && s_tready) begin
      since_acc <= '0;
      if (cfg_taps == '0)                    want_lat <= CW'(3);
      else if (int'(cfg_taps) > DEPTH)       want_lat <= CW'(DEPTH + 2);
      else                                   want_lat <= CW'(cfg_taps) + CW'(2);
    end else if (since_acc != '1) begin
      since_acc <= since_acc + 1'b1;
    end
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    ($past(rst) && !rst) |-> (!m_tvalid && !m_tlast && s_tready));

  // R4
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(m_tvalid) |-> (since_acc == want_lat));

  // R5
  one_in_flight_chk: assert property (@(posedge clk) disable iff (rst)
    (s_tvalid && s_tready) |=> !s_tready);

  // R6
  hold_output_chk: assert property (@(posedge clk) disable iff (rst)
    (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tlast)));

  // R9
  last_with_valid_chk: assert property (@(posedge clk) disable iff (rst)
    m_tlast |-> m_tvalid);

endmodule

bind fir_stream_top fir_stream_chk #(.DATA_W(DATA_W), .AW(AW)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .cfg_taps (cfg_taps),
  .s_tvalid (s_tvalid),
  .s_tready (s_tready),
  .m_tvalid (m_tvalid),
  .m_tready (m_tready),
  .m_tdata  (m_tdata),
  .m_tlast  (m_tlast)
);

// File: tb/fir_stream_top_tb_top.sv
module fir_stream_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 32;
  localparam int AW     = 4;
  localparam int LEN_W  = 16;
  localparam int DEPTH  = 1 << AW;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [AW:0]       cfg_taps = '0;
  logic [LEN_W-1:0]  cfg_len = '0;
  logic              coef_we = 1'b0;
  logic [AW-1:0]     coef_idx = '0;
  logic [DATA_W-1:0] coef_data = '0;
  logic              s_tvalid = 1'b0;
  logic              s_tready;
  logic [DATA_W-1:0] s_tdata = '0;
  logic              m_tvalid;
  logic              m_tready = 1'b1;
  logic [DATA_W-1:0] m_tdata;
  logic              m_tlast;

  int n_checks = 0;
  int n_fails  = 0;
  int hc [DEPTH];
  int xs [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  fir_stream_top #(.DATA_W(DATA_W), .AW(AW), .LEN_W(LEN_W)) dut_i (
    .clk(clk), .rst(rst), .cfg_taps(cfg_taps), .cfg_len(cfg_len),
    .coef_we(coef_we), .coef_idx(coef_idx), .coef_data(coef_data),
    .s_tvalid(s_tvalid), .s_tready(s_tready), .s_tdata(s_tdata),
    .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tdata(m_tdata), .m_tlast(m_tlast)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; s_tvalid = 1'b0; m_tready = 1'b1; coef_we = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    xs.delete();
    @(negedge clk);
  endtask

  task automatic load_coefs(input int mode);
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      case (mode)
        0: hc[i] = i + 1;
        1: hc[i] = (i % 2 == 0) ? (3 * i - 7) : (-5 * i + 2);
        default: hc[i] = 32'h7fff_fff0 - i * 32'h1357_9bdf;
      endcase
      coef_we = 1'b1; coef_idx = AW'(i); coef_data = hc[i];
    end
    @(negedge clk);
    coef_we = 1'b0;
  endtask

  function automatic int model(input int t);
    int acc = 0;
    int n = xs.size() - 1;
    for (int k = 0; k < t; k++)
      if (n - k >= 0) acc = acc + hc[k] * xs[n - k];
    return acc;
  endfunction

  // drive one sample, wait for its result; returns latency in edges
  task automatic send(input int x, output int lat);
    while (!s_tready) @(negedge clk);
    s_tvalid = 1'b1; s_tdata = x;
    @(posedge clk);
    xs.push_back(x);
    @(negedge clk);
    s_tvalid = 1'b0;
    lat = 0;
    while (!m_tvalid && lat < 500) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic send_check(input int x, input int t, input string req);
    int lat;
    int exp;
    send(x, lat);
    exp = model(t);
    check(m_tdata == exp, req, int'(m_tdata), exp);
    check(lat == t + 2, "R4 latency", lat, t + 2);
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    check(s_tready == 1'b1, "R1 s_tready", s_tready, 1);
    check(m_tvalid == 1'b0, "R1 m_tvalid", m_tvalid, 0);
    check(m_tlast == 1'b0, "R1 m_tlast", m_tlast, 0);
  endtask

  task automatic t_basic();
    do_reset();
    cfg_taps = 5; cfg_len = 100;
    load_coefs(1);
    for (int i = 0; i < 9; i++) send_check(i * 11 - 30, 5, "R2 dot product");
  endtask

  task automatic t_backpressure();
    int lat;
    logic [DATA_W-1:0] held;
    do_reset();
    cfg_taps = 3; cfg_len = 100;
    load_coefs(0);
    m_tready = 1'b0;
    send(17, lat);
    held = m_tdata;
    check(m_tdata == model(3), "R2 held value", int'(m_tdata), model(3));
    for (int i = 0; i < 6; i++) begin
      s_tvalid = 1'b1; s_tdata = 999;
      @(negedge clk);
      check(m_tvalid && m_tdata == held, "R6 hold", int'(m_tdata), int'(held));
      check(s_tready == 1'b0, "R5 ready low while pending", s_tready, 0);
    end
    s_tvalid = 1'b0;
    m_tready = 1'b1;
    @(negedge clk);
    check(m_tvalid == 1'b0, "R6 released", m_tvalid, 0);
    check(s_tready == 1'b1, "R5 ready back", s_tready, 1);
    send_check(4, 3, "R5 no extra sample taken");
  endtask

  task automatic t_wrap();
    do_reset();
    cfg_taps = DEPTH; cfg_len = 100;
    load_coefs(1);
    for (int i = 0; i < DEPTH + 5; i++) send_check(i * 7 + 3, DEPTH, "R7 ring wrap");
  endtask

  task automatic t_clamp();
    do_reset();
    cfg_len = 100;
    load_coefs(0);
    cfg_taps = 0;
    send_check(25, 1, "R8 zero taps");
    send_check(-9, 1, "R8 zero taps");
    cfg_taps = 5'd31;
    send_check(40, DEPTH, "R8 taps above depth");
    cfg_taps = 5'd17;
    send_check(-6, DEPTH, "R8 taps above depth");
  endtask

  task automatic t_wrap_arith();
    do_reset();
    cfg_taps = 4; cfg_len = 100;
    load_coefs(2);
    send_check(32'h7fff_ffff, 4, "R3 wrap");
    send_check(32'h8000_0001, 4, "R3 wrap");
    send_check(32'h1234_5678, 4, "R3 wrap");
  endtask

  task automatic t_frames();
    int lat;
    do_reset();
    cfg_taps = 2; cfg_len = 3;
    load_coefs(0);
    for (int i = 0; i < 7; i++) begin
      send(i + 1, lat);
      check(m_tlast == ((i % 3) == 2), "R9 tlast", m_tlast, (i % 3) == 2);
      @(negedge clk);
    end
  endtask

  initial begin
    t_reset();
    t_basic();
    t_backpressure();
    t_wrap();
    t_clamp();
    t_wrap_arith();
    t_frames();
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end

endmodule